// File: doc/BRIEF.md
# Transhybrid Balance Filter

This block forms an echo estimate of the receive signal that leaks through the two-to-four-wire hybrid, and removes it from the transmit signal. Each 16 kHz sample period it takes one signed receive sample and one signed transmit sample. The receive sample first passes through a one-pole recursive section, then through an eight-tap transversal section. The transversal result is subtracted from the transmit sample, and the difference is saturated to 16 bits.

A single multiplier-accumulator is shared by the nine coefficient products. It works through them in the clock cycles that follow a sample strobe. Coefficients come from a nine-entry user-writable store. A select input can replace them with a fixed default set. Whichever set applies is copied at the moment a sample is accepted, so a write never disturbs a computation that is already running.

All arithmetic is Q1.15 with floor rounding (arithmetic right shift by 15) and a 40-bit accumulator.

Top module: `hybrid_bal_filter`

## Requirements
- R1: A synchronous reset drives `balOut` to 0 and `balValid` to 0. It clears the recursive state, the delay line and all nine user coefficients to zero.
- R2: For an accepted sample x, the recursive section computes w = sat16((x·2^15 + a·wPrev) >>> 15). The feedback coefficient a is held at address 0, and wPrev is the previous w.
- R3: The transversal result is f = sat16((Σ h_k·w[n−k], k = 0..7) >>> 15). Tap h_k is held at address 1+k, and w[n] is the newest value.
- R4: `balOut` = sat16(tx − f). It updates, together with a one-cycle `balValid` pulse, exactly 10 clock edges after the edge that accepts the sample. It holds its value at all other times.
- R5: A `sampleValid` strobe that arrives while a sample is being processed is ignored. It changes neither the result nor the state.
- R6: A coefficient write at addresses 0..8 takes effect from the next accepted sample. A write made during processing does not change the result being computed.
- R7: When `useDefaultCoef` is 1 at sample acceptance, the fixed set a = 8192 and h_k = 16384 >>> k is used instead of the user store. The user store stays intact for later samples.
- R8: Writes to addresses 9..15 are ignored.
- R9: Every saturation clamps to the range −32768..32767, both in the recursive state and in the final difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Sample strobe, one cycle per sample period |
| rxSample | input | 16 | Signed receive-path sample |
| txSample | input | 16 | Signed transmit-path sample |
| useDefaultCoef | input | 1 | Select the fixed default coefficient set |
| cfgWrEn | input | 1 | Coefficient write enable |
| cfgAddr | input | 4 | Coefficient address (0 = feedback, 1..8 = taps) |
| cfgData | input | 16 | Coefficient value, Q1.15 |
| balOut | output | 16 | Balanced transmit sample |
| balValid | output | 1 | One-cycle pulse when balOut updates |

## Verification
The hardest case to reach from the ports is a write, or a stray strobe, that lands inside the ten-cycle processing window. The expected result then depends on which coefficient set was copied and which sample was really taken. The sample task can raise a write or a junk strobe on a chosen cycle inside that window. The bench model applies the write only after the current result and discards the junk sample. The saturation paths are reached with feedback and taps set near full scale and full-scale inputs, so that both the recursive state and the output difference clip.

// File: rtl/hbal_pkg.sv
package hbal_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int TAPS     = 8;
  localparam int ACC_W    = 40;
  localparam int FRAC     = COEF_W - 1;
  localparam int NCOEF    = TAPS + 1;
  localparam int STEP_W   = $clog2(NCOEF + 1);
  localparam int TAP_W    = $clog2(TAPS);
  localparam int ADDR_W   = 4;

  typedef struct packed {
    logic             load;
    logic             iirStep;
    logic             macStep;
    logic [TAP_W-1:0] tapSel;
    logic             finish;
  } strobe_t;

  // Fixed set: feedback 0.25, taps halving from 0.5
  function automatic logic [COEF_W-1:0] defaultCoef(input int idx);
    if (idx == 0) return COEF_W'(8192);
    return COEF_W'(16384 >>> (idx - 1));
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] sat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] hi, lo;
    hi = ACC_W'((1 <<< (SAMPLE_W - 1)) - 1);
    lo = -hi - ACC_W'(1);
    if (v > hi) return hi[SAMPLE_W-1:0];
    if (v < lo) return lo[SAMPLE_W-1:0];
    return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/hbal_ctrl.sv
module hbal_ctrl
  import hbal_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleValid,
  output strobe_t strobe,
  output logic    busy
);
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      if (sampleValid) begin
        busy <= 1'b1;
        step <= '0;
      end
    end else if (step == STEP_W'(NCOEF)) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = !busy && sampleValid;
    strobe.iirStep = busy && (step == '0);
    strobe.macStep = busy && (step != '0) && (step <= STEP_W'(TAPS));
    strobe.tapSel  = TAP_W'(step - STEP_W'(1));
    strobe.finish  = busy && (step == STEP_W'(NCOEF));
  end

  // R4: the phases of one sample never overlap
  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.iirStep, strobe.macStep, strobe.finish}));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(NCOEF));

  // R5: a strobe during processing does not restart the sequence
  assert_busy_ignores_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && sampleValid && step != STEP_W'(NCOEF)) |=> (busy && step == $past(step) + STEP_W'(1)));
endmodule

// File: rtl/hbal_datapath.sv
module hbal_datapath
  import hbal_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobe,
  input  logic signed [SAMPLE_W-1:0] rxSample,
  input  logic signed [SAMPLE_W-1:0] txSample,
  input  logic                       useDefault,
  input  logic                       cfgWrEn,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [COEF_W-1:0]          cfgData,
  output logic signed [SAMPLE_W-1:0] outSample,
  output logic                       outValid
);
  logic [NCOEF-1:0][COEF_W-1:0]  userCoef;
  logic [NCOEF-1:0][COEF_W-1:0]  actCoef;
  logic signed [SAMPLE_W-1:0]    xReg, txReg, wPrev;
  logic signed [SAMPLE_W-1:0]    dline [TAPS];
  logic signed [ACC_W-1:0]       acc;

  logic [STEP_W-1:0]             tapIdx;
  logic signed [COEF_W-1:0]      coefOp;
  logic signed [SAMPLE_W-1:0]    dataOp;
  logic signed [COEF_W+SAMPLE_W-1:0] product;
  logic signed [ACC_W-1:0]       prodExt, iirSum, diff;
  logic signed [SAMPLE_W-1:0]    wNew, firRes;

  // User coefficient store, one register per address
  for (genvar i = 0; i < NCOEF; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) userCoef[i] <= '0;
      else if (cfgWrEn && cfgAddr == ADDR_W'(i)) userCoef[i] <= cfgData;
    end
  end

  // Shared multiplier operands
  always_comb begin
    tapIdx  = STEP_W'(strobe.tapSel) + STEP_W'(1);
    coefOp  = strobe.iirStep ? $signed(actCoef[0]) : $signed(actCoef[tapIdx]);
    dataOp  = strobe.iirStep ? wPrev : dline[strobe.tapSel];
    product = coefOp * dataOp;
    prodExt = ACC_W'(product);
    iirSum  = (ACC_W'(xReg) <<< FRAC) + prodExt;
    wNew    = sat(iirSum >>> FRAC);
    firRes  = sat(acc >>> FRAC);
    diff    = ACC_W'(txReg) - ACC_W'(firRes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actCoef   <= '0;
      xReg      <= '0;
      txReg     <= '0;
      wPrev     <= '0;
      acc       <= '0;
      outSample <= '0;
      outValid  <= 1'b0;
      for (int k = 0; k < TAPS; k++) dline[k] <= '0;
    end else begin
      outValid <= strobe.finish;
      if (strobe.load) begin
        xReg  <= rxSample;
        txReg <= txSample;
        for (int i = 0; i < NCOEF; i++)
          actCoef[i] <= useDefault ? defaultCoef(i) : userCoef[i];
      end
      if (strobe.iirStep) begin
        wPrev    <= wNew;
        dline[0] <= wNew;
        for (int k = 1; k < TAPS; k++) dline[k] <= dline[k-1];
        acc <= '0;
      end
      if (strobe.macStep) acc <= acc + prodExt;
      if (strobe.finish) outSample <= sat(diff);
    end
  end

  // R4: output changes only on the finishing cycle, valid is a single pulse
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.finish |=> $stable(outSample));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6: the working set changes only at a sample boundary
  assert_coef_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.iirStep || strobe.macStep || strobe.finish) |=> $stable(actCoef));

  // R8: out-of-range addresses leave the store untouched
  assert_bad_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (cfgWrEn && cfgAddr >= ADDR_W'(NCOEF)) |=> $stable(userCoef));
endmodule

// File: rtl/hybrid_bal_filter.sv
module hybrid_bal_filter
  import hbal_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] rxSample,
  input  logic signed [SAMPLE_W-1:0] txSample,
  input  logic                       useDefaultCoef,
  input  logic                       cfgWrEn,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [COEF_W-1:0]          cfgData,
  output logic signed [SAMPLE_W-1:0] balOut,
  output logic                       balValid
);
  strobe_t strobe;
  logic    busy;

  hbal_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .strobe(strobe), .busy(busy)
  );

  hbal_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rxSample(rxSample), .txSample(txSample), .useDefault(useDefaultCoef),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outSample(balOut), .outValid(balValid)
  );

  // R4: a result is only announced at the end of a busy window
  assert_valid_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    balValid |-> $past(busy));
endmodule

// File: tb/hybrid_bal_filter_bench.sv
module hybrid_bal_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst = 1;
  logic sampleValid = 0;
  logic signed [15:0] rxSample = '0, txSample = '0;
  logic useDefaultCoef = 0;
  logic cfgWrEn = 0;
  logic [3:0] cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic signed [15:0] balOut;
  logic balValid;

  int checks = 0, fails = 0;

  // bench model state
  int mUser [9];
  int mW;
  int mDl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_bal_filter u_hybrid_bal_filter (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .rxSample(rxSample), .txSample(txSample), .useDefaultCoef(useDefaultCoef),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .balOut(balOut), .balValid(balValid)
  );

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int dflt(input int idx);
    if (idx == 0) return 8192;
    return 16384 >>> (idx - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mW = 0;
    for (int k = 0; k < 8; k++) mDl[k] = 0;
    for (int i = 0; i < 9; i++) mUser[i] = 0;
  endtask

  function automatic int modelStep(input int x, input int tx, input bit useD);
    longint s;
    int c [9];
    for (int i = 0; i < 9; i++) c[i] = useD ? dflt(i) : mUser[i];
    s = (longint'(x) <<< 15) + longint'(c[0]) * longint'(mW);
    mW = sat16(s >>> 15);
    for (int k = 7; k > 0; k--) mDl[k] = mDl[k-1];
    mDl[0] = mW;
    s = 0;
    for (int k = 0; k < 8; k++) s += longint'(c[k+1]) * longint'(mDl[k]);
    return sat16(longint'(tx) - longint'(sat16(s >>> 15)));
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    modelReset();
  endtask

  task automatic wrCoef(input int addr, input int data);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = 4'(addr); cfgData = 16'(data);
    @(negedge clk);
    cfgWrEn = 0;
    if (addr < 9) mUser[addr] = (data >= 32768) ? data - 65536 : data;
  endtask

  // one sample; optional junk strobe (R5) or write (R6) inside the busy window
  task automatic runSample(input int x, input int tx, input bit useD,
                           input bit inject, input bit midWr,
                           input int wAddr, input int wData, input string tag);
    int exp;
    @(negedge clk);
    sampleValid = 1; rxSample = 16'(x); txSample = 16'(tx); useDefaultCoef = useD;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 0;
    for (int i = 1; i <= 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 9) check(balValid == 0, "R4 early valid", int'(balValid), 0);
      if (i == 2 && midWr) begin
        cfgWrEn = 1; cfgAddr = 4'(wAddr); cfgData = 16'(wData);
      end
      if (i == 3) cfgWrEn = 0;
      if (i == 3 && inject) begin
        sampleValid = 1; rxSample = 16'(x ^ 16'h5a5a); txSample = 16'(tx + 999);
        useDefaultCoef = !useD;
      end
      if (i == 4) begin sampleValid = 0; useDefaultCoef = useD; end
    end
    exp = modelStep(x, tx, useD);
    if (midWr && wAddr < 9) mUser[wAddr] = (wData >= 32768) ? wData - 65536 : wData;
    check(balValid == 1, {tag, " valid"}, int'(balValid), 1);
    check(int'(balOut) == exp, tag, int'(balOut), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hv [8];
    hv = '{20000, -10000, 5000, -2500, 1000, 0, -300, 32767};
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check(balOut == 0, "R1 reset out", int'(balOut), 0);
    check(balValid == 0, "R1 reset valid", int'(balValid), 0);
    // R1 cleared coefficients: output equals tx
    runSample(12345, -4321, 0, 0, 0, 0, 0, "R1 zero coef");

    // R2 R3 impulse and step responses
    wrCoef(0, 16384);
    for (int k = 0; k < 8; k++) wrCoef(k + 1, hv[k] & 16'hffff);
    runSample(10000, 0, 0, 0, 0, 0, 0, "R2 impulse");
    for (int n = 0; n < 12; n++) runSample(0, 0, 0, 0, 0, 0, 0, "R3 impulse tail");
    for (int n = 0; n < 12; n++) runSample(-7000, 1500, 0, 0, 0, 0, 0, "R3 step");

    // R4 broad sweep of input patterns
    for (int n = 0; n < 64; n++)
      runSample(((n * 1237) % 34000) - 17000, n * 523 - 16000, 0, 0, 0, 0, 0, "R4 sweep");
    for (int n = 0; n < 16; n++)
      runSample((n % 2) ? 30000 : -30000, (n % 3) * 8000, 0, 0, 0, 0, 0, "R4 alternate");

    // R5 junk strobe during processing
    for (int n = 0; n < 6; n++) runSample(n * 3000 - 9000, 200 * n, 0, 1, 0, 0, 0, "R5 ignored strobe");

    // R6 writes inside the busy window apply from the next sample
    runSample(8000, 100, 0, 0, 1, 1, 16'h8000, "R6 mid write");
    runSample(-8000, 100, 0, 0, 1, 0, 30000, "R6 after write");
    runSample(5000, -100, 0, 0, 0, 0, 0, "R6 new feedback");

    // R8 out-of-range addresses
    for (int a = 9; a < 16; a++) wrCoef(a, 32767);
    for (int n = 0; n < 4; n++) runSample(4000 - n * 2500, 0, 0, 0, 0, 0, 0, "R8 bad address");

    // R7 default set, then back to the user set
    for (int n = 0; n < 10; n++) runSample((n == 0) ? 16000 : 0, 50, 1, 0, 0, 0, 0, "R7 default");
    for (int n = 0; n < 4; n++) runSample(-3000, 0, 0, 0, 0, 0, 0, "R7 user again");

    // R9 saturation both ways
    wrCoef(0, 32767);
    wrCoef(1, 32767);
    for (int k = 2; k < 9; k++) wrCoef(k, 0);
    for (int n = 0; n < 6; n++) runSample(32767, -32768, 0, 0, 0, 0, 0, "R9 negative clip");
    wrCoef(1, 16'h8000);
    for (int n = 0; n < 4; n++) runSample(32767, 32767, 0, 0, 0, 0, 0, "R9 positive clip");
    for (int n = 0; n < 6; n++) runSample(-32768, 0, 0, 0, 0, 0, 0, "R9 state clip");

    // R1 reset mid-run clears state and store
    doReset();
    check(balOut == 0, "R1 out after reset", int'(balOut), 0);
    wrCoef(0, 20000);
    wrCoef(1, 30000);
    runSample(0, 777, 0, 0, 0, 0, 0, "R1 state cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule